// File: doc/BRIEF.md
# Bitmap Text Display Scanner

The scanner drives a raster display from a byte-organised monochrome bitmap buffer. Each screen pixel is one bit of the buffer. A horizontal and a vertical counter produce the line sync and the frame sync. In the visible area the scanner addresses the buffer, fetching one byte for every eight pixels. It loads each byte into a shift register and sends it out most significant bit first as a single video bit. This spacing is what lets 16x16 glyph cells work. A cell row is two adjacent bytes, and the next cell row sits one line stride further on, 80 bytes at the default width.

The buffer has a single address bus, and the scanner shares it with an external microcontroller. A visible flag is high while the beam is in the active area. While it is high the scanner owns the bus and blocks all microcontroller writes. During blanking the bus carries the microcontroller's address, and a write passes only if the top bit of its 16-bit address is clear. The default geometry is 640x400 pixels with 800 clocks per line and 434 lines per frame. At a 25 MHz pixel clock this gives about 31 kHz line rate and about 72 Hz frame rate. A full 400-line frame needs 32000 bytes of the 32K-byte buffer.

Top module: `crt_bitmap_scanner`

## Requirements
- R1: Reset behaviour.
  - While reset is low, hsync_o and vsync_o are high, video_o and buf_we_o are 0, and the counters sit at pixel 0 of line 0.
  - At that point vis_o is 1 and buf_addr_o is 0.
  - The first clock after reset release advances to pixel 1.
- R2: Visible flag and line layout.
  - vis_o is 1 exactly when pixel h is below H_BYTES*8 and line v is below V_ACTIVE.
  - Each line runs active pixels, then H_FP, then H_SYNC, then H_BP.
  - Each frame runs the same four intervals in lines: V_ACTIVE, V_FP, V_SYNC, V_BP.
- R3: hsync_o is active low. It is low for the H_SYNC pixels starting at pixel H_BYTES*8+H_FP, delayed by two clocks so it lines up with the video.
- R4: vsync_o is active low. It is low on the V_SYNC lines starting at line V_ACTIVE+V_FP, with the same two-clock delay.
- R5: Scan addressing.
  - While vis_o is 1, buf_addr_o equals v*H_BYTES + h/8.
  - The address restarts at 0 on every frame.
  - The same column on the next line is one stride (H_BYTES) higher.
- R6: While vis_o is 0, buf_addr_o equals bits 14..0 of mcu_addr_i.
- R7: buf_we_o is 1 exactly when mcu_wr_i is 1, bit 15 of mcu_addr_i is 0 and vis_o is 0. It is therefore never 1 in the visible area.
- R8: Video timing and bit order.
  - buf_rdata_i is the buffer byte at the address presented one clock earlier.
  - Pixel (h,v) appears on video_o two clocks after the scanner is at that pixel, as bit 7-(h mod 8) of its byte.
  - Bytes follow each other without gaps.
- R9: video_o is 0 whenever the two-clock-delayed visible flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcu_addr_i | input | 16 | Microcontroller address; bit 15 high disables writes |
| mcu_wr_i | input | 1 | Microcontroller write request |
| buf_rdata_i | input | 8 | Buffer read data, one clock after the address |
| buf_addr_o | output | 15 | Shared buffer address |
| buf_we_o | output | 1 | Buffer write enable |
| vis_o | output | 1 | Beam in visible area, bus owned by scanner |
| hsync_o | output | 1 | Line sync, active low |
| vsync_o | output | 1 | Frame sync, active low |
| video_o | output | 1 | Serial video bit |

## Verification
A slipped counter shows at once in buf_addr_o and vis_o, in the very cycle the count goes wrong. It reaches the sync outputs two clocks later, as a wrong pulse position or width. A shift register that is loaded or shifted wrongly corrupts video_o within eight pixels of the faulty byte. A scan address that does not restart gives wrong pixels from the first line of the next frame. A lockout fault raises buf_we_o inside the visible area and then changes later pixels, because the overwritten bytes are read back.

// File: rtl/crt_scan_pkg.sv
package crt_scan_pkg;
  typedef struct packed {
    logic act;
    logic hs_n;
    logic vs_n;
  } beam_t;

  localparam beam_t BEAM_IDLE = '{act: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
endpackage

// File: rtl/crt_raster_timer.sv
module crt_raster_timer
  import crt_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 400,
  parameter int V_FP     = 12,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 20,
  parameter int HW       = 10,
  parameter int VW       = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output beam_t         beam_o,
  output logic          fetch_o,
  output logic          adv_o,
  output logic          frame_end_o
);
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HS_START = H_ACTIVE + H_FP;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FP;
  localparam int VS_END   = VS_START + V_SYNC;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic line_end, last_line;

  assign line_end  = (h_q == HW'(H_TOTAL - 1));
  assign last_line = (v_q == VW'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= last_line ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  always_comb begin
    beam_o.act  = (h_q < HW'(H_ACTIVE)) && (v_q < VW'(V_ACTIVE));
    beam_o.hs_n = !((h_q >= HW'(HS_START)) && (h_q < HW'(HS_END)));
    beam_o.vs_n = !((v_q >= VW'(VS_START)) && (v_q < VW'(VS_END)));
  end

  // byte boundaries within the active span
  assign fetch_o     = beam_o.act && (h_q[2:0] == 3'd0);
  assign adv_o       = beam_o.act && (h_q[2:0] == 3'd7);
  assign frame_end_o = line_end && last_line;
  assign h_o         = h_q;
  assign v_o         = v_q;
endmodule

// File: rtl/crt_scan_addr.sv
module crt_scan_addr #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          clr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  // continuous count: the line stride falls out of the active width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (adv_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/crt_pipe_delay.sv
module crt_pipe_delay #(
  parameter int             W       = 1,
  parameter int             DEPTH   = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/crt_pixel_shifter.sv
module crt_pixel_shifter #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] data_i,
  input  logic          vis_i,
  output logic          video_o
);
  logic [BW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= data_i;
    else             sr_q <= {sr_q[BW-2:0], 1'b0};
  end

  assign video_o = vis_i & sr_q[BW-1];
endmodule

// File: rtl/crt_bitmap_scanner.sv
module crt_bitmap_scanner
  import crt_scan_pkg::*;
#(
  parameter int H_BYTES  = 80,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 400,
  parameter int V_FP     = 12,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 20,
  parameter int AW       = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW:0]   mcu_addr_i,
  input  logic          mcu_wr_i,
  input  logic [7:0]    buf_rdata_i,
  output logic [AW-1:0] buf_addr_o,
  output logic          buf_we_o,
  output logic          vis_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          video_o
);
  localparam int H_ACTIVE = H_BYTES * 8;
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int BEAM_W   = $bits(beam_t);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  beam_t         beam, beam_d2;
  logic          fetch, adv, frame_end, fetch_d1;
  logic [AW-1:0] scan_addr;

  crt_raster_timer #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_o(h_cnt), .v_o(v_cnt),
    .beam_o(beam), .fetch_o(fetch), .adv_o(adv), .frame_end_o(frame_end)
  );

  crt_scan_addr #(.AW(AW)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .clr_i(frame_end),
    .addr_o(scan_addr)
  );

  // fetch strobe trails the address by the buffer read latency
  crt_pipe_delay #(.W(1), .DEPTH(1), .RST_VAL(1'b0)) u_fetch_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fetch), .q_o(fetch_d1)
  );

  // syncs and blanking follow the video by two clocks
  crt_pipe_delay #(.W(BEAM_W), .DEPTH(2), .RST_VAL(BEAM_IDLE)) u_beam_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(beam), .q_o(beam_d2)
  );

  crt_pixel_shifter #(.BW(8)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fetch_d1), .data_i(buf_rdata_i),
    .vis_i(beam_d2.act), .video_o(video_o)
  );

  // bus ownership follows the undelayed visible flag
  assign vis_o      = beam.act;
  assign buf_addr_o = beam.act ? scan_addr : mcu_addr_i[AW-1:0];
  assign buf_we_o   = !beam.act && mcu_wr_i && !mcu_addr_i[AW];
  assign hsync_o    = beam_d2.hs_n;
  assign vsync_o    = beam_d2.vs_n;
endmodule

// File: rtl/crt_bitmap_scanner_chk.sv
module crt_bitmap_scanner_chk #(
  parameter int H_TOTAL = 800,
  parameter int H_SYNC  = 96,
  parameter int V_SYNC  = 2,
  parameter int HW      = 10,
  parameter int VW      = 9,
  parameter int AW      = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [HW-1:0] h_i,
  input logic [VW-1:0] v_i,
  input logic [AW:0]   mcu_addr_i,
  input logic          mcu_wr_i,
  input logic [AW-1:0] buf_addr_i,
  input logic          buf_we_i,
  input logic          vis_i,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic          video_i
);
  int unsigned hs_cnt, vs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_cnt <= 0;
      vs_cnt <= 0;
    end else begin
      hs_cnt <= hsync_i ? 0 : hs_cnt + 1;
      vs_cnt <= vsync_i ? 0 : vs_cnt + 1;
    end
  end

  p_no_we_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_i |-> !buf_we_i);

  p_we_needs_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> (mcu_wr_i && !mcu_addr_i[AW]));

  p_dark_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vis_i, 2) |-> !video_i);

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vis_i && $past(vis_i)) |->
      ((buf_addr_i == $past(buf_addr_i)) || (buf_addr_i == $past(buf_addr_i) + 1'b1)));

  p_frame_origin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vis_i && h_i == '0 && v_i == '0) |-> (buf_addr_i == '0));

  p_hsync_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_i) |-> (hs_cnt == H_SYNC));

  p_vsync_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_i) |-> (vs_cnt == V_SYNC * H_TOTAL));
endmodule

bind crt_bitmap_scanner crt_bitmap_scanner_chk #(
  .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .V_SYNC(V_SYNC),
  .HW(HW), .VW(VW), .AW(AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .h_i(h_cnt), .v_i(v_cnt),
  .mcu_addr_i(mcu_addr_i), .mcu_wr_i(mcu_wr_i), .buf_addr_i(buf_addr_o),
  .buf_we_i(buf_we_o), .vis_i(vis_o), .hsync_i(hsync_o), .vsync_i(vsync_o),
  .video_i(video_o)
);

// File: tb/crt_bitmap_scanner_bench.sv
`timescale 1ns/1ps
module crt_bitmap_scanner_bench;
  localparam int BPL = 4;
  localparam int HA  = BPL * 8;
  localparam int HFP = 4, HSY = 4, HBP = 4;
  localparam int VA  = 5, VFP = 1, VSY = 2, VBP = 1;
  localparam int HT  = HA + HFP + HSY + HBP;
  localparam int VT  = VA + VFP + VSY + VBP;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mcu_addr = '0;
  logic        mcu_wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [14:0] buf_addr;
  logic        buf_we, vis, hsync, vsync, video;

  int n_chk = 0, n_err = 0;
  logic [7:0] ram [64];
  logic [7:0] shadow [64];

  always #2.5 clk = ~clk;

  crt_bitmap_scanner #(
    .H_BYTES(BPL), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)
  ) u_crt_bitmap_scanner (
    .clk_i(clk), .rst_ni(rst_ni), .mcu_addr_i(mcu_addr), .mcu_wr_i(mcu_wr),
    .buf_rdata_i(rdata), .buf_addr_o(buf_addr), .buf_we_o(buf_we),
    .vis_o(vis), .hsync_o(hsync), .vsync_o(vsync), .video_o(video)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 91) ^ (i << 3));
  endfunction

  // buffer model: registered read, write port driven by the scanner
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) ram[i] <= init_byte(i);
    end else if (buf_we) begin
      ram[buf_addr[5:0]] <= wdata;
    end
    rdata <= ram[buf_addr[5:0]];
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  function automatic bit exp_vis(int h, int v);
    return (h < HA) && (v < VA);
  endfunction

  function automatic bit exp_hs(int h);
    return !((h >= HA + HFP) && (h < HA + HFP + HSY));
  endfunction

  function automatic bit exp_vs(int v);
    return !((v >= VA + VFP) && (v < VA + VFP + VSY));
  endfunction

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int h, v;
    bit d1_act, d2_act, d1_hs, d2_hs, d1_vs, d2_vs, d1_f, d2_f;
    int d1_h, d2_h;
    logic [7:0] d1_b, d2_b, cur_byte;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) shadow[i] = init_byte(i);

    // R1: state while reset is held, with a write request pending
    mcu_wr = 1'b1;
    mcu_addr = 16'h0003;
    repeat (3) @(negedge clk);
    #1;
    chk(hsync == 1'b1, "R1 hsync in reset", hsync, 1);
    chk(vsync == 1'b1, "R1 vsync in reset", vsync, 1);
    chk(video == 1'b0, "R1 video in reset", video, 0);
    chk(buf_we == 1'b0, "R1 we in reset", buf_we, 0);
    chk(vis == 1'b1, "R1 origin visible", vis, 1);
    chk(buf_addr == 15'd0, "R1 origin address", buf_addr, 0);
    mcu_wr = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    h = 0; v = 0;
    d1_act = 0; d2_act = 0; d1_hs = 1; d2_hs = 1; d1_vs = 1; d2_vs = 1;
    d1_f = 0; d2_f = 0; d1_h = 0; d2_h = 0; d1_b = '0; d2_b = '0; cur_byte = '0;

    for (int cyc = 0; cyc < 4 * FRAME; cyc++) begin
      int fr;
      bit act, f, we_e, vid_e;
      int addr_e;
      logic [7:0] fb;
      fr = cyc / FRAME;
      // frame 0 idle, frame 2 hammers writes, others random
      case (fr)
        0: begin
          mcu_wr = 1'b0;
          mcu_addr = 16'($urandom);
        end
        2: begin
          mcu_wr = 1'b1;
          mcu_addr = {1'b0, 15'($urandom)};
        end
        default: begin
          mcu_wr = ($urandom % 3) == 0;
          mcu_addr = {($urandom % 4) == 0, 15'($urandom)};
        end
      endcase
      wdata = 8'($urandom);
      #1;
      act = exp_vis(h, v);
      addr_e = act ? (v * BPL + h / 8) : int'(mcu_addr[14:0]);
      we_e = !act && mcu_wr && !mcu_addr[15];
      f = act && (h % 8 == 0);
      fb = f ? shadow[addr_e[5:0]] : 8'h00;
      if (d2_f) cur_byte = d2_b;
      vid_e = d2_act ? cur_byte[7 - (d2_h % 8)] : 1'b0;

      chk(vis == act, "R2 visible flag", vis, act);
      if (act) chk(int'(buf_addr) == addr_e, "R5 scan address", buf_addr, addr_e);
      else     chk(int'(buf_addr) == addr_e, "R6 blank address", buf_addr, addr_e);
      chk(buf_we == we_e, "R7 write enable", buf_we, we_e);
      chk(hsync == d2_hs, "R3 hsync", hsync, d2_hs);
      chk(vsync == d2_vs, "R4 vsync", vsync, d2_vs);
      if (d2_act) chk(video == vid_e, "R8 video bit", video, vid_e);
      else        chk(video == 1'b0, "R9 blank video", video, 0);

      d2_act = d1_act; d2_hs = d1_hs; d2_vs = d1_vs; d2_f = d1_f; d2_h = d1_h; d2_b = d1_b;
      d1_act = act; d1_hs = exp_hs(h); d1_vs = exp_vs(v); d1_f = f; d1_h = h; d1_b = fb;
      if (we_e) shadow[mcu_addr[5:0]] = wdata;
      if (h == HT - 1) begin
        h = 0;
        v = (v == VT - 1) ? 0 : v + 1;
      end else begin
        h = h + 1;
      end
      @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule